// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches one 16-bit word from a serial EEPROM with separate select, clock, data-to-device and data-from-device lines. A client raises a request for one cycle with an 8-bit word address. The block then drives the EEPROM pins through a fixed series of 63 pin states and captures the word the device shifts back. When the series ends, the block gives the word together with a one-cycle completion pulse.

Every pin state is held for `SETTLE` system clocks before the next state is applied, so the EEPROM sees a slow, well-settled waveform whatever the system clock rate. The series is made of a wake-up preamble, a start bit and a read command, the address, a quiet step, sixteen read clocks and a deselect tail. Read data is taken from the device line in the last system clock of each low-clock read step, so it has had a full settle interval after the falling edge.

Top module: `ee_word_reader`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle: `busy` and `done` low and `sel_o`, `sck_o`, `sdo_o` all low.
- R2: A `rd_req` seen while idle is accepted at that edge. `busy` is high from the next cycle until the cycle in which `done` pulses high for exactly one cycle, and in that cycle `busy` is low.
- R3: Each of the 63 pin states is held for exactly `SETTLE` system clocks, so `busy` stays high for 63×`SETTLE` cycles.
- R4: The transfer opens with four states, written as (select, clock, data-out): (0,0,0), (1,0,0), (1,1,0), (1,0,0).
- R5: Three command bits follow, valued 1, 1, 0 (start bit, then read command 10). Each bit is shown with clock low and then with clock high, with select held high.
- R6: The 8 address bits follow, most significant bit first. Each bit is shown with clock low and then with clock high, with select high.
- R7: One state (1,0,0) follows. Then come 16 read bits, each a state (1,1,0) and then a state (1,0,0). `sdi_i` is sampled in the last cycle of each (1,0,0) state, and the first bit sampled becomes bit 15 of `rd_word`.
- R8: The transfer closes with the states (0,0,0), (1,0,0), (0,0,0), (0,1,0). The pins then stay at (0,1,0) until the next accepted request.
- R9: A `rd_req` raised while `busy` is high is ignored. The transfer in progress keeps its address and gives only one `done`.
- R10: `rd_word` carries the captured word when `done` is high. It holds that value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | One-cycle read request |
| rd_addr | input | 8 | Word address, sampled when a request is accepted |
| sdi_i | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse marking the end of a transfer |
| rd_word | output | 16 | Word read from the EEPROM |
| sel_o | output | 1 | EEPROM chip select |
| sck_o | output | 1 | EEPROM serial clock |
| sdo_o | output | 1 | Serial data to the EEPROM |

## Verification
The assertions check the following on every cycle: pins never change inside a settle interval, `busy` and `done` are never high together, `done` lasts one cycle, the pins are at the clock-only state whenever `done` fires, `rd_word` moves only on a sample strobe or at acceptance, and reset clears the pins. Other properties need the scenarios. These are the exact order of the 63 pin states, the command and address bits an EEPROM model decodes from them, the captured word's bit order compared against that model, the total transfer length, and the proof that a request arriving mid-transfer does not alter the address or add a completion.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    // Protocol widths fixed by the device command format
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    // Step counts for each segment of a read transfer
    localparam int PRE_N  = 4;
    localparam int CMD_BITS_N = 3;
    localparam int CMD_N  = 2 * CMD_BITS_N;
    localparam int ADR_N  = 2 * ADDR_W;
    localparam int DAT_N  = 2 * DATA_W;
    localparam int TAIL_N = 4;

    localparam int CMD_BASE  = PRE_N;
    localparam int ADR_BASE  = CMD_BASE + CMD_N;
    localparam int GAP_IDX   = ADR_BASE + ADR_N;
    localparam int DAT_BASE  = GAP_IDX + 1;
    localparam int TAIL_BASE = DAT_BASE + DAT_N;
    localparam int NUM_STEPS = TAIL_BASE + TAIL_N;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    // Start bit then read command, sent left to right
    localparam logic [CMD_BITS_N-1:0] CMD_BITS = 3'b110;

    typedef struct packed {
        logic sel;
        logic sclk;
        logic dout;
    } pins_t;

    typedef enum logic [2:0] {
        SEG_PRE,
        SEG_CMD,
        SEG_ADR,
        SEG_GAP,
        SEG_DAT,
        SEG_TAIL
    } seg_e;

    function automatic seg_e seg_of(input int idx);
        if (idx < CMD_BASE)       return SEG_PRE;
        else if (idx < ADR_BASE)  return SEG_CMD;
        else if (idx < GAP_IDX)   return SEG_ADR;
        else if (idx == GAP_IDX)  return SEG_GAP;
        else if (idx < TAIL_BASE) return SEG_DAT;
        else                      return SEG_TAIL;
    endfunction

    // Pin vector driven during step idx for word address a
    function automatic pins_t step_pins(input int idx, input logic [ADDR_W-1:0] a);
        pins_t p;
        int    off;
        p   = '0;
        off = 0;
        unique case (seg_of(idx))
            SEG_PRE: begin
                off    = idx;
                p.sel  = (off != 0);
                p.sclk = (off == 2);
            end
            SEG_CMD: begin
                off    = idx - CMD_BASE;
                p.sel  = 1'b1;
                p.sclk = ((off % 2) == 1);
                p.dout = CMD_BITS[CMD_BITS_N-1-(off/2)];
            end
            SEG_ADR: begin
                off    = idx - ADR_BASE;
                p.sel  = 1'b1;
                p.sclk = ((off % 2) == 1);
                p.dout = a[ADDR_W-1-(off/2)];
            end
            SEG_GAP: begin
                p.sel = 1'b1;
            end
            SEG_DAT: begin
                off    = idx - DAT_BASE;
                p.sel  = 1'b1;
                p.sclk = ((off % 2) == 0);
            end
            default: begin
                off    = idx - TAIL_BASE;
                p.sel  = (off == 1);
                p.sclk = (off == 3);
            end
        endcase
        return p;
    endfunction

    // True for the low-clock half of each read bit
    function automatic logic is_sample(input int idx);
        return (seg_of(idx) == SEG_DAT) && (((idx - DAT_BASE) % 2) == 1);
    endfunction

endpackage

// File: rtl/ee_settle_timer.sv
module ee_settle_timer #(
    parameter int SETTLE = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // R3
    settle_idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R3
    settle_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/ee_step_seq.sv
module ee_step_seq
    import ee_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              expire,
    output logic              busy,
    output logic              done,
    output logic              start,
    output logic              sample,
    output pins_t             pins
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] addr_q;

    assign start  = req && !busy;
    assign sample = busy && expire && is_sample(int'(step_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            step_q <= '0;
            addr_q <= '0;
            pins   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (req) begin
                    busy   <= 1'b1;
                    addr_q <= req_addr;
                    step_q <= '0;
                    pins   <= step_pins(0, req_addr);
                end
            end else if (expire) begin
                if (step_q == LAST_STEP) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                    pins   <= step_pins(int'(step_q) + 1, addr_q);
                end
            end
        end
    end

    // R1
    reset_pins_low_chk: assert property (@(posedge clk)
        rst |=> (pins == '0 && !busy && !done));

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire) |=> $stable(pins));

    // R8
    end_state_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pins.sclk && !pins.sel && !pins.dout));

    // R9
    busy_addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> $stable(addr_q));

endmodule

// File: rtl/ee_rx_shift.sv
module ee_rx_shift
    import ee_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              sdi,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) word <= '0;
        else if (sample)  word <= {word[DATA_W-2:0], sdi};
    end

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample && !clear) |=> $stable(word));

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
    import ee_rd_pkg::*;
#(
    parameter int SETTLE = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sdi_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_word,
    output logic              sel_o,
    output logic              sck_o,
    output logic              sdo_o
);
    logic  expire;
    logic  start;
    logic  sample;
    pins_t pins;

    ee_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .expire (expire)
    );

    ee_step_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (rd_req),
        .req_addr (rd_addr),
        .expire   (expire),
        .busy     (busy),
        .done     (done),
        .start    (start),
        .sample   (sample),
        .pins     (pins)
    );

    ee_rx_shift u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .sample (sample),
        .sdi    (sdi_i),
        .word   (rd_word)
    );

    assign sel_o = pins.sel;
    assign sck_o = pins.sclk;
    assign sdo_o = pins.dout;

endmodule

// File: tb/ee_word_reader_test.sv
module ee_word_reader_test;
    localparam int S     = 3;
    localparam int NSTEP = 63;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        sdi;
    logic        busy, done, sel, sck, sdo;
    logic [15:0] rd_word;

    always #4 clk = ~clk;

    ee_word_reader #(.SETTLE(S)) uut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .sdi_i(sdi),
        .busy(busy), .done(done), .rd_word(rd_word),
        .sel_o(sel), .sck_o(sck), .sdo_o(sdo)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_done = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a ^ 8'h3C, ~a};
    endfunction

    // Expected (select, clock, data-out) for step k, from R4..R8
    function automatic logic [2:0] exp_vec(input int k, input logic [7:0] a);
        int o;
        if (k < 4) return (k == 0) ? 3'b000 : (k == 2) ? 3'b110 : 3'b100;
        if (k < 10) begin
            o = k - 4;
            return {1'b1, 1'(o % 2), (o < 4) ? 1'b1 : 1'b0};
        end
        if (k < 26) begin
            o = k - 10;
            return {1'b1, 1'(o % 2), a[7 - o / 2]};
        end
        if (k == 26) return 3'b100;
        if (k < 59) return (((k - 27) % 2) == 0) ? 3'b110 : 3'b100;
        case (k - 59)
            0:       return 3'b000;
            1:       return 3'b100;
            2:       return 3'b000;
            default: return 3'b010;
        endcase
    endfunction

    function automatic string step_req(input int k);
        if (k < 4)  return "R4";
        if (k < 10) return "R5";
        if (k < 26) return "R6";
        if (k < 59) return "R7";
        return "R8";
    endfunction

    // EEPROM model: decodes command, drives data on rising clocks
    int          m_state = 0;
    int          m_cnt   = 0;
    logic [9:0]  m_cmd   = '0;
    logic [15:0] m_word  = '0;
    logic        m_psck  = 1'b0;
    initial sdi = 1'b0;

    always @(negedge clk) begin
        if (rst || !sel) begin
            m_state = 0;
            m_cnt   = 0;
            sdi     = 1'b0;
        end else if (sck && !m_psck) begin
            if (m_state == 0) begin
                if (sdo) begin
                    m_state = 1;
                    m_cnt   = 0;
                end
            end else if (m_state == 1) begin
                m_cmd = {m_cmd[8:0], sdo};
                m_cnt++;
                if (m_cnt == 10) begin
                    check(m_cmd[9:8] == 2'b10, "R5", "read opcode", m_cmd[9:8], 2);
                    if (exp_q.size() > 0)
                        check(m_cmd[7:0] == exp_q[0], "R6", "address bits",
                              m_cmd[7:0], exp_q[0]);
                    m_word  = mem_word(m_cmd[7:0]);
                    m_state = 2;
                    m_cnt   = 0;
                end
            end else begin
                if (m_cnt < 16) sdi = m_word[15 - m_cnt];
                m_cnt++;
            end
        end
        m_psck = sck;
    end

    // Monitor / scoreboard
    int cyc = 0;
    always @(negedge clk) begin
        int k;
        int r;
        logic [7:0] a;
        if (rst) begin
            cyc = 0;
        end else begin
            if (busy) begin
                if (exp_q.size() > 0) begin
                    k = cyc / S;
                    r = cyc % S;
                    if (r == 0 || r == S - 1)
                        check({sel, sck, sdo} == exp_vec(k, exp_q[0]), step_req(k),
                              $sformatf("pins step %0d", k), {sel, sck, sdo},
                              exp_vec(k, exp_q[0]));
                end
                cyc++;
            end
            if (done) begin
                n_done++;
                check(cyc == NSTEP * S, "R3", "busy length", cyc, NSTEP * S);
                check(!busy, "R2", "busy low at done", busy, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    a = exp_q.pop_front();
                    check(rd_word == mem_word(a), "R7", "word", rd_word, mem_word(a));
                    check(rd_word == mem_word(a), "R10", "word at done", rd_word, mem_word(a));
                end
                cyc = 0;
            end
        end
    end

    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_q.push_back(a);
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        rd_req = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int d0;
        rst     = 1'b1;
        rd_req  = 1'b0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        check({sel, sck, sdo} == 3'b000, "R1", "pins in reset", {sel, sck, sdo}, 0);
        rst = 1'b0;

        do_read(8'h00);
        wait_done();
        repeat (5) @(negedge clk);
        check(rd_word == mem_word(8'h00), "R10", "word hold", rd_word, mem_word(8'h00));
        check({sel, sck, sdo} == 3'b010, "R8", "idle pins", {sel, sck, sdo}, 3'b010);

        do_read(8'hFF);
        wait_done();
        do_read(8'h5A);
        wait_done();

        // R9: request during a transfer is dropped
        do_read(8'h81);
        repeat (20) @(negedge clk);
        d0 = n_done;
        rd_req  = 1'b1;
        rd_addr = 8'h24;
        @(negedge clk);
        rd_req = 1'b0;
        wait_done();
        repeat (S * 10) @(negedge clk);
        check(!busy, "R9", "no second transfer", busy, 0);
        check(n_done == d0 + 1, "R9", "single done", n_done, d0 + 1);

        // back-to-back
        do_read(8'hC3);
        wait_done();
        do_read(8'h3C);
        wait_done();

        // R1: reset mid-transfer
        do_read(8'h77);
        repeat (50) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done, "R1", "busy after mid reset", {busy, done}, 0);
        check({sel, sck, sdo} == 3'b000, "R1", "pins after mid reset", {sel, sck, sdo}, 0);

        do_read(8'h12);
        wait_done();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all reads completed", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule